// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block joins an A port to a B port through a set of byte lanes that work independently of each other. Two lanes of 8 bits each are the default. Each port is split into an input vector, an output vector and a per-bit output-enable vector, so the pads can sit outside the block. Within a lane, an active-low enable and a direction bit choose which port the lane drives, if any. The driven port then carries either the live value from the opposite port or a value held in a per-direction storage register.

Each lane has two capture strobes, one for each direction. A strobe is sampled on the system clock, and its rising edge loads the matching storage register from its source port. Capture keeps working while the lane drives either port and while the lane is isolated. A system can therefore latch traffic from both sides and replay it later. If all lanes share the same controls, the block acts as one 16-bit transceiver.

Top module: `dual_lane_xcvr`

## Requirements
- R1: Each lane responds only to its own control bits (bit n of each control vector steers data bits n*8 to n*8+7); changing one lane's controls or strobes leaves the other lane's outputs, enables and stored data unchanged.
- R2: The A-side register of a lane loads that lane's a_in byte on a clock edge where its ab_strobe bit is 1 and was 0 at the previous clock edge; the new value is visible from the next cycle.
- R3: The B-side register of a lane loads that lane's b_in byte on a clock edge where its ba_strobe bit is 1 and was 0 at the previous clock edge; the new value is visible from the next cycle.
- R4: Capture does not depend on oe_n or dir; while oe_n is 1 the lane drives neither port (its a_oe and b_oe bits are all 0) and still captures.
- R5: While oe_n is 0, dir=0 sets every a_oe bit of the lane and dir=1 sets every b_oe bit; a lane never has a_oe and b_oe bits set at the same time.
- R6: While the lane drives A, sel_ba=0 gives a_out = b_in in the same cycle, and sel_ba=1 gives a_out = the stored B-side register.
- R7: While the lane drives B, sel_ab=0 gives b_out = a_in in the same cycle, and sel_ab=1 gives b_out = the stored A-side register.
- R8: When both strobes of a lane rise at the same clock edge, both registers capture at that edge.
- R9: An output byte whose enable is 0 reads as zero.
- R10: A clock edge with rst high clears every storage register to zero.
- R11: A strobe held high over several clock edges captures only at its first edge; later changes on the port are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 0 drives A, 1 drives B |
| ab_strobe | input | 2 | Per-lane capture strobe for the A-side register |
| ba_strobe | input | 2 | Per-lane capture strobe for the B-side register |
| sel_ab | input | 2 | Per-lane source for B output: 0 live, 1 stored |
| sel_ba | input | 2 | Per-lane source for A output: 0 live, 1 stored |
| a_in | input | 16 | A port input value |
| a_out | output | 16 | A port output value |
| a_oe | output | 16 | A port per-bit output enable |
| b_in | input | 16 | B port input value |
| b_out | output | 16 | B port output value |
| b_oe | output | 16 | B port per-bit output enable |

## Verification
A register can only be observed when it is replayed through the output mux. Two cases are the hardest to see from the ports: a capture made while the lane is isolated, and a strobe held high across a data change. In each case the stimulus first changes the port value, then switches the lane to drive the opposite port with the stored source selected, so that a wrong capture would show up as a different byte. To test lane independence, one lane's strobe is held while the other lane is read back and still shows its older stored byte.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      DRV_OFF = 2'd0,
      DRV_A   = 2'd1,
      DRV_B   = 2'd2
   } drive_e;

   function automatic drive_e pick_drive(input logic en_n, input logic to_b);
      if (en_n)
         return DRV_OFF;
      return to_b ? DRV_B : DRV_A;
   endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);

   logic lvl_q;

   always_ff @(posedge clk) begin
      if (rst)
         lvl_q <= 1'b0;
      else
         lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

   AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);  // R11

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= d;
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(d)));  // R2

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));  // R11

   AST_RST_CLEARS: assert property (@(posedge clk)
      rst |=> (q == '0));  // R10

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         oe_n,
   input  logic         dir,
   input  logic         ab_strobe,
   input  logic         ba_strobe,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   logic         ab_rise, ba_rise;
   logic [W-1:0] a_held, b_held;
   logic [W-1:0] to_a, to_b;
   drive_e       drv;

   xcvr_edge_det u_ab_edge (.clk(clk), .rst(rst), .lvl(ab_strobe), .rise(ab_rise));
   xcvr_edge_det u_ba_edge (.clk(clk), .rst(rst), .lvl(ba_strobe), .rise(ba_rise));

   xcvr_store #(.W(W)) u_a_store (
      .clk(clk), .rst(rst), .load(ab_rise), .d(a_in), .q(a_held));
   xcvr_store #(.W(W)) u_b_store (
      .clk(clk), .rst(rst), .load(ba_rise), .d(b_in), .q(b_held));

   assign drv  = pick_drive(oe_n, dir);
   assign to_a = sel_ba ? b_held : b_in;
   assign to_b = sel_ab ? a_held : a_in;

   always_comb begin
      a_oe  = {W{drv == DRV_A}};
      b_oe  = {W{drv == DRV_B}};
      a_out = (drv == DRV_A) ? to_a : '0;
      b_out = (drv == DRV_B) ? to_b : '0;
   end

   AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
      !((|a_oe) && (|b_oe)));  // R5

   AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> (a_oe == '0 && b_oe == '0));  // R4

   AST_QUIET_A: assert property (@(posedge clk) disable iff (rst)
      (a_oe == '0) |-> (a_out == '0));  // R9

   AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && dir && !sel_ab) |-> (b_out == a_in));  // R7

   AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && !dir && !sel_ba) |-> (a_out == b_in));  // R6

endmodule

// File: rtl/dual_lane_xcvr.sv
module dual_lane_xcvr #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int TOT_W = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LANES-1:0] oe_n,
   input  logic [LANES-1:0] dir,
   input  logic [LANES-1:0] ab_strobe,
   input  logic [LANES-1:0] ba_strobe,
   input  logic [LANES-1:0] sel_ab,
   input  logic [LANES-1:0] sel_ba,
   input  logic [TOT_W-1:0] a_in,
   output logic [TOT_W-1:0] a_out,
   output logic [TOT_W-1:0] a_oe,
   input  logic [TOT_W-1:0] b_in,
   output logic [TOT_W-1:0] b_out,
   output logic [TOT_W-1:0] b_oe
);

   if (LANES < 1) begin : g_bad_lanes
      $error("dual_lane_xcvr: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("dual_lane_xcvr: LANE_W must be at least 1");
   end

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      localparam int LO = n * LANE_W;

      xcvr_lane #(.W(LANE_W)) u_lane (
         .clk       (clk),
         .rst       (rst),
         .oe_n      (oe_n[n]),
         .dir       (dir[n]),
         .ab_strobe (ab_strobe[n]),
         .ba_strobe (ba_strobe[n]),
         .sel_ab    (sel_ab[n]),
         .sel_ba    (sel_ba[n]),
         .a_in      (a_in[LO +: LANE_W]),
         .b_in      (b_in[LO +: LANE_W]),
         .a_out     (a_out[LO +: LANE_W]),
         .a_oe      (a_oe[LO +: LANE_W]),
         .b_out     (b_out[LO +: LANE_W]),
         .b_oe      (b_oe[LO +: LANE_W])
      );
   end

endmodule

// File: tb/dual_lane_xcvr_tb.sv
module dual_lane_xcvr_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  oe_n = 2'b11, dir = 2'b00;
   logic [1:0]  ab_strobe = 2'b00, ba_strobe = 2'b00;
   logic [1:0]  sel_ab = 2'b00, sel_ba = 2'b00;
   logic [15:0] a_in = '0, b_in = '0;
   logic [15:0] a_out, a_oe, b_out, b_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dual_lane_xcvr u_dut (
      .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
      .ab_strobe(ab_strobe), .ba_strobe(ba_strobe),
      .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic ctl(input logic [1:0] en_n, input logic [1:0] d,
                      input logic [1:0] s_ab, input logic [1:0] s_ba);
      oe_n = en_n; dir = d; sel_ab = s_ab; sel_ba = s_ba;
      #2;
   endtask

   task automatic pulse(input logic [1:0] ab, input logic [1:0] ba);
      @(negedge clk); ab_strobe = ab; ba_strobe = ba;
      @(negedge clk); ab_strobe = 2'b00; ba_strobe = 2'b00;
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      ctl(2'b00, 2'b00, 2'b00, 2'b11);
      chk("R10 B store zero after reset", a_out, 16'h0000);
      ctl(2'b00, 2'b11, 2'b11, 2'b00);
      chk("R10 A store zero after reset", b_out, 16'h0000);
   endtask

   task automatic t_live;
      @(negedge clk);
      a_in = 16'h5A3C; b_in = 16'hC0DE;
      ctl(2'b00, 2'b11, 2'b00, 2'b00);
      chk("R7 live a_in to b_out", b_out, 16'h5A3C);
      chk("R5 b_oe set for dir=1", b_oe, 16'hFFFF);
      chk("R9 a_out zero when undriven", a_out, 16'h0000);
      a_in = 16'h0F0F; #2;
      chk("R7 live follows same cycle", b_out, 16'h0F0F);
      ctl(2'b00, 2'b00, 2'b00, 2'b00);
      chk("R6 live b_in to a_out", a_out, 16'hC0DE);
      chk("R5 a_oe set for dir=0", a_oe, 16'hFFFF);
   endtask

   task automatic t_isolated_capture;
      @(negedge clk);
      a_in = 16'h1234; b_in = 16'hABCD;
      ctl(2'b11, 2'b00, 2'b00, 2'b00);
      chk("R4 isolated a_oe", a_oe, 16'h0000);
      chk("R4 isolated b_oe", b_oe, 16'h0000);
      chk("R9 isolated b_out zero", b_out, 16'h0000);
      pulse(2'b11, 2'b11);
      a_in = 16'h9999; b_in = 16'h7777;
      ctl(2'b00, 2'b11, 2'b11, 2'b00);
      chk("R8 R2 A store after joint capture", b_out, 16'h1234);
      ctl(2'b00, 2'b00, 2'b00, 2'b11);
      chk("R8 R3 B store after joint capture", a_out, 16'hABCD);
   endtask

   task automatic t_level_hold;
      @(negedge clk);
      a_in = 16'h5511;
      ab_strobe = 2'b01;
      @(negedge clk);
      a_in = 16'h6622;
      @(negedge clk);
      a_in = 16'h7733;
      @(negedge clk);
      ab_strobe = 2'b00;
      ctl(2'b00, 2'b11, 2'b11, 2'b00);
      chk("R11 held strobe keeps first byte, R1 lane1 unchanged", b_out, 16'h1211);
   endtask

   task automatic t_lane_split;
      @(negedge clk);
      a_in = 16'hA1B2; b_in = 16'hC3D4;
      ctl(2'b00, 2'b10, 2'b00, 2'b00);
      chk("R1 a_oe lane0 only", a_oe, 16'h00FF);
      chk("R1 b_oe lane1 only", b_oe, 16'hFF00);
      chk("R1 a_out lane0 live", a_out, 16'h00D4);
      chk("R1 b_out lane1 live", b_out, 16'hA100);
      ctl(2'b10, 2'b00, 2'b00, 2'b00);
      chk("R1 lane1 isolated, lane0 drives A", a_oe, 16'h00FF);
      chk("R1 lane1 isolated b_oe", b_oe, 16'h0000);
   endtask

   task automatic t_capture_while_driving;
      @(negedge clk);
      a_in = 16'h7788;
      ctl(2'b00, 2'b00, 2'b00, 2'b00);
      pulse(2'b11, 2'b00);
      a_in = 16'h0000;
      ctl(2'b00, 2'b11, 2'b11, 2'b00);
      chk("R4 R2 capture while driving A", b_out, 16'h7788);
      ctl(2'b00, 2'b00, 2'b00, 2'b11);
      chk("R3 B store untouched by A strobe", a_out, 16'hABCD);
   endtask

   task automatic t_reset_clear;
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      ctl(2'b00, 2'b11, 2'b11, 2'b00);
      chk("R10 A store cleared", b_out, 16'h0000);
      ctl(2'b00, 2'b00, 2'b00, 2'b11);
      chk("R10 B store cleared", a_out, 16'h0000);
   endtask

   task automatic t_exclusive;
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         logic [15:0] exp_a, exp_b;
         ctl({k[3], k[2]}, {k[1], k[0]}, 2'b00, 2'b00);
         exp_a = { {8{~k[3] & ~k[1]}}, {8{~k[2] & ~k[0]}} };
         exp_b = { {8{~k[3] &  k[1]}}, {8{~k[2] &  k[0]}} };
         chk("R5 a_oe decode", a_oe, exp_a);
         chk("R5 b_oe decode", b_oe, exp_b);
         chk("R5 never both sides", a_oe & b_oe, 16'h0000);
      end
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_live();
      t_isolated_capture();
      t_level_hold();
      t_lane_split();
      t_capture_while_driving();
      t_reset_clear();
      t_exclusive();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule